// File: doc/BRIEF.md
# 100 Mb/s Twisted-Pair Descrambler with Lock Supervision

This block sits on the receive path of a 100 Mb/s twisted-pair port, after clock and data recovery. It takes one recovered code bit per clock, qualified by a valid strobe. It removes the additive stream cipher that the far end applied, and it hands the plain bits on as 5-bit code groups aligned to the boundaries expected by a downstream 4B5B decoder.

The block finds the cipher state on its own while the line carries idle. Idle is all ones before scrambling, so each received bit gives one key bit. After it locks, a supervisor counts valid bits in fixed windows. Each window must contain a run of consecutive descrambled ones of at least a minimum length, or lock is dropped and acquisition starts again. Code-group framing is taken from the start-of-stream delimiter and is kept until lock is lost.

A bypass control lets an unscrambled stream pass through unchanged. The lock supervision is then switched off. When the speed input selects 10 Mb/s, the whole block stays idle.

Top module: `descr100_rx`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `locked` and `grp_vld` are low; reset clears the key register, all counters and the framing.
- R2: The key bit is `s[10] XOR s[8]` of an 11-bit shift register (x^11 + x^9 + 1), which then shifts that key bit in at bit 0 on every valid bit; each descrambled bit is the received bit XOR the key bit.
- R3: Acquisition loads the register with the inverted received bits for 11 valid bits. It then checks each valid bit against the predicted idle value, and `locked` rises right after the 11 + `LOCK_CNT` (default 30) valid bit; a mismatch discards that bit and restarts the load; cycles with `rx_vld` low have no effect.
- R4: Once locked, the block stays locked through every window of `WIN_LEN` valid bits in which a run of at least `RUN_MIN` (default 25) consecutive descrambled ones completes, or is still going on.
- R5: When a window ends with no such run while locked, `locked` falls at that window's last bit and acquisition restarts.
- R6: While locked and not yet framed, no code group is emitted until the descrambled bits 1100010001 arrive, earliest bit first. The block then emits 11000 and, in the next cycle, 10001, and after that every 5 valid bits as one group with the earliest bit in `grp_data[4]`.
- R7: `grp_vld` is high only in a cycle that follows a cycle with `locked` high; framing is forgotten when lock is lost, and no group leaves the block while it is unlocked.
- R8: With `scr_bypass` high and `mode_100` high, bits pass through without XOR, `locked` is high and no window check can drop it; any change of `scr_bypass` forgets the framing.
- R9: With `mode_100` low, `locked` and `grp_vld` are low and acquisition state is cleared, so a return to 100 Mb/s needs a full reacquisition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Recovered code bit |
| rx_vld | input | 1 | `rx_bit` carries a new bit this cycle |
| scr_bypass | input | 1 | Pass bits through without descrambling |
| mode_100 | input | 1 | 1 selects 100 Mb/s, 0 selects 10 Mb/s (block idle) |
| grp_data | output | 5 | Aligned code group, earliest bit in bit 4 |
| grp_vld | output | 1 | `grp_data` holds a new group this cycle |
| locked | output | 1 | Descrambler synchronized (or bypassed) |

## Verification
The bench counts the valid bits to lock exactly. It spreads idle cycles through acquisition and injects a single wrong bit partway through verification. A design that counted clocks instead of bits, or that failed to restart the load, would lock one bit early or late. Lock supervision is tried with runs of exactly 25 ones, which must hold lock across several windows, and with runs of 24 ones, which must lose it. An off-by-one in the run counter makes one of these two cases fail. Framing is checked by landing the delimiter at a bit offset that is not a multiple of five, in both scrambled and bypass operation, and by checking that nothing is emitted before the delimiter, after lock loss, or in 10 Mb/s mode.

// File: rtl/descr100_pkg.sv
package descr100_pkg;

    // Key generator: 11 stages, feedback from the top stage and stage 8.
    localparam int KEY_W   = 11;
    localparam int KEY_TAP = 8;

    // Code-group width and the start-of-stream delimiter (earliest bit left).
    localparam int GRP_W = 5;
    localparam logic [2*GRP_W-1:0] SSD_PAT = 10'b11000_10001;

    typedef enum logic [1:0] {
        SYNC_LOAD   = 2'd0,
        SYNC_VERIFY = 2'd1,
        SYNC_LOCK   = 2'd2
    } sync_st_e;

    typedef struct packed {
        logic [GRP_W-1:0] data;
        logic             vld;
    } grp_t;

    function automatic logic key_of(input logic [KEY_W-1:0] s);
        return s[KEY_W-1] ^ s[KEY_TAP];
    endfunction

endpackage

// File: rtl/descr100_sync.sv
module descr100_sync
    import descr100_pkg::*;
#(
    parameter int LOCK_CNT = 30
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     active,
    input  logic     bit_vld,
    input  logic     rx_bit,
    input  logic     win_fail,
    output logic     key,
    output sync_st_e st
);
    localparam int LCW = $clog2(KEY_W);
    localparam int VCW = $clog2(LOCK_CNT + 1);
    localparam logic [LCW-1:0] LD_LAST  = LCW'(KEY_W - 1);
    localparam logic [VCW-1:0] VER_LAST = VCW'(LOCK_CNT - 1);

    logic [KEY_W-1:0] lfsr_q;
    logic [LCW-1:0]   ld_cnt_q;
    logic [VCW-1:0]   ver_cnt_q;
    sync_st_e         st_q;

    assign key = key_of(lfsr_q);
    assign st  = st_q;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            st_q      <= SYNC_LOAD;
            lfsr_q    <= '0;
            ld_cnt_q  <= '0;
            ver_cnt_q <= '0;
        end else if (bit_vld) begin
            case (st_q)
                SYNC_LOAD: begin
                    // Idle plaintext is all ones, so the key bit is the inverted code bit.
                    lfsr_q <= {lfsr_q[KEY_W-2:0], ~rx_bit};
                    if (ld_cnt_q == LD_LAST) begin
                        ld_cnt_q  <= '0;
                        ver_cnt_q <= '0;
                        st_q      <= SYNC_VERIFY;
                    end else begin
                        ld_cnt_q <= ld_cnt_q + 1'b1;
                    end
                end
                SYNC_VERIFY: begin
                    lfsr_q <= {lfsr_q[KEY_W-2:0], key};
                    if (rx_bit == ~key) begin
                        if (ver_cnt_q == VER_LAST) begin
                            st_q <= SYNC_LOCK;
                        end else begin
                            ver_cnt_q <= ver_cnt_q + 1'b1;
                        end
                    end else begin
                        st_q      <= SYNC_LOAD;
                        ld_cnt_q  <= '0;
                        ver_cnt_q <= '0;
                    end
                end
                SYNC_LOCK: begin
                    lfsr_q <= {lfsr_q[KEY_W-2:0], key};
                    if (win_fail) begin
                        st_q     <= SYNC_LOAD;
                        ld_cnt_q <= '0;
                    end
                end
                default: st_q <= SYNC_LOAD;
            endcase
        end
    end

    // R3: lock is only ever entered from the verify phase.
    p_lock_from_verify_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q == SYNC_LOCK && $past(st_q) != SYNC_LOCK) |-> $past(st_q) == SYNC_VERIFY);

    // R5: while enabled, lock is only left at a failed window end.
    p_drop_at_window_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q) == SYNC_LOCK && st_q != SYNC_LOCK && $past(active)) |-> $past(win_fail));

endmodule

// File: rtl/descr100_winmon.sv
module descr100_winmon #(
    parameter int WIN_LEN = 125000,
    parameter int RUN_MIN = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic bit_vld,
    input  logic dbit,
    input  logic tracking,
    output logic win_fail
);
    localparam int WCW = $clog2(WIN_LEN);
    localparam int RCW = $clog2(RUN_MIN + 1);
    localparam logic [WCW-1:0] WIN_LAST = WCW'(WIN_LEN - 1);
    localparam logic [RCW-1:0] RUN_TOP  = RCW'(RUN_MIN);
    localparam logic [RCW-1:0] RUN_PRE  = RCW'(RUN_MIN - 1);

    logic [WCW-1:0] win_cnt_q;
    logic [RCW-1:0] run_cnt_q;
    logic           flag_q;
    logic           win_end;
    logic           run_full_now;

    assign win_end      = bit_vld && (win_cnt_q == WIN_LAST);
    assign run_full_now = bit_vld && tracking && dbit && (run_cnt_q >= RUN_PRE);
    assign win_fail     = win_end && !(flag_q || run_full_now);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            win_cnt_q <= '0;
            run_cnt_q <= '0;
            flag_q    <= 1'b0;
        end else begin
            if (bit_vld) begin
                win_cnt_q <= win_end ? '0 : win_cnt_q + 1'b1;
            end
            if (!tracking) begin
                run_cnt_q <= '0;
            end else if (bit_vld) begin
                if (!dbit) begin
                    run_cnt_q <= '0;
                end else if (run_cnt_q != RUN_TOP) begin
                    run_cnt_q <= run_cnt_q + 1'b1;
                end
            end
            if (win_end) begin
                flag_q <= 1'b0;
            end else if (run_full_now) begin
                flag_q <= 1'b1;
            end
        end
    end

    // R4: the run flag is only ever cleared by a window boundary while enabled.
    p_flag_clear_at_end_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(flag_q) && $past(enable)) |-> $past(win_end));

    // R4: a run flag is only raised by a descrambled one while tracking.
    p_flag_rise_on_one_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(tracking && dbit && bit_vld));

endmodule

// File: rtl/descr100_align.sv
module descr100_align
    import descr100_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sync,
    input  logic             bypass,
    input  logic             bit_vld,
    input  logic             dbit,
    output logic [GRP_W-1:0] grp_data,
    output logic             grp_vld
);
    localparam int HW  = 2 * GRP_W;
    localparam int PHW = $clog2(GRP_W);
    localparam logic [PHW-1:0] PH_LAST = PHW'(GRP_W - 1);

    logic [HW-1:0]  hist_q;
    logic [HW-1:0]  hist_n;
    logic [PHW-1:0] phase_q;
    logic           aligned_q;
    logic           pend_k_q;
    logic           byp_q;
    logic           ssd_hit;
    grp_t           grp_q;

    assign hist_n   = {hist_q[HW-2:0], dbit};
    assign ssd_hit  = bit_vld && sync && !aligned_q && (hist_n == SSD_PAT);
    assign grp_data = grp_q.data;
    assign grp_vld  = grp_q.vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q    <= '0;
            phase_q   <= '0;
            aligned_q <= 1'b0;
            pend_k_q  <= 1'b0;
            byp_q     <= 1'b0;
            grp_q     <= '0;
        end else begin
            byp_q     <= bypass;
            grp_q.vld <= 1'b0;
            if (bit_vld) begin
                hist_q <= hist_n;
            end
            if (!sync || (bypass != byp_q)) begin
                aligned_q <= 1'b0;
                pend_k_q  <= 1'b0;
                phase_q   <= '0;
            end else begin
                if (pend_k_q) begin
                    grp_q.data <= SSD_PAT[GRP_W-1:0];
                    grp_q.vld  <= 1'b1;
                    pend_k_q   <= 1'b0;
                end
                if (ssd_hit) begin
                    aligned_q  <= 1'b1;
                    phase_q    <= '0;
                    pend_k_q   <= 1'b1;
                    grp_q.data <= SSD_PAT[HW-1:GRP_W];
                    grp_q.vld  <= 1'b1;
                end else if (bit_vld && aligned_q) begin
                    if (phase_q == PH_LAST) begin
                        phase_q    <= '0;
                        grp_q.data <= hist_n[GRP_W-1:0];
                        grp_q.vld  <= 1'b1;
                    end else begin
                        phase_q <= phase_q + 1'b1;
                    end
                end
            end
        end
    end

    // R6: framing starts with the first delimiter group on the output.
    p_ssd_emits_j_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(aligned_q) |-> (grp_q.vld && grp_q.data == SSD_PAT[HW-1:GRP_W]));

    // R6: the second delimiter group follows in the very next cycle.
    p_k_follows_j_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(aligned_q) && sync && (bypass == byp_q)) |=>
            (grp_q.vld && grp_q.data == SSD_PAT[GRP_W-1:0]));

endmodule

// File: rtl/descr100_rx.sv
module descr100_rx
    import descr100_pkg::*;
#(
    parameter int WIN_LEN  = 125000,
    parameter int RUN_MIN  = 25,
    parameter int LOCK_CNT = 30
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_bit,
    input  logic             rx_vld,
    input  logic             scr_bypass,
    input  logic             mode_100,
    output logic [GRP_W-1:0] grp_data,
    output logic             grp_vld,
    output logic             locked
);
    logic     active;
    logic     key;
    logic     dbit;
    logic     tracking;
    logic     win_fail;
    sync_st_e st;

    assign active   = mode_100 && !scr_bypass;
    assign dbit     = scr_bypass ? rx_bit : (rx_bit ^ key);
    assign tracking = (st == SYNC_VERIFY) || (st == SYNC_LOCK);
    assign locked   = mode_100 && (scr_bypass || (st == SYNC_LOCK));

    descr100_sync #(.LOCK_CNT(LOCK_CNT)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .bit_vld  (rx_vld),
        .rx_bit   (rx_bit),
        .win_fail (win_fail),
        .key      (key),
        .st       (st)
    );

    descr100_winmon #(.WIN_LEN(WIN_LEN), .RUN_MIN(RUN_MIN)) winmon_i (
        .clk      (clk),
        .rst      (rst),
        .enable   (active),
        .bit_vld  (rx_vld),
        .dbit     (dbit),
        .tracking (tracking),
        .win_fail (win_fail)
    );

    descr100_align align_i (
        .clk      (clk),
        .rst      (rst),
        .sync     (locked),
        .bypass   (scr_bypass),
        .bit_vld  (rx_vld),
        .dbit     (dbit),
        .grp_data (grp_data),
        .grp_vld  (grp_vld)
    );

    // R7: a group only leaves after a cycle in which lock was held.
    p_vld_needs_lock_r7: assert property (@(posedge clk) disable iff (rst)
        grp_vld |-> $past(locked));

    // R9: the 10 Mb/s setting silences the output.
    p_quiet_10m_r9: assert property (@(posedge clk) disable iff (rst)
        !mode_100 |=> !grp_vld);

endmodule

// File: tb/descr100_rx_tb_top.sv
module descr100_rx_tb_top;
    localparam int WIN = 300;
    localparam int NV  = 8;
    // {plain group sent, group expected at the output}
    localparam logic [9:0] VEC [0:NV-1] = '{
        {5'b11110, 5'b11110}, {5'b01001, 5'b01001}, {5'b10100, 5'b10100},
        {5'b10101, 5'b10101}, {5'b01010, 5'b01010}, {5'b01011, 5'b01011},
        {5'b01110, 5'b01110}, {5'b01111, 5'b01111}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_bit = 1'b0;
    logic       rx_vld = 1'b0;
    logic       scr_bypass = 1'b0;
    logic       mode_100 = 1'b1;
    logic [4:0] grp_data;
    logic       grp_vld;
    logic       locked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [10:0] scr = 11'h5A3;
    logic [4:0]  cap [0:1023];
    int          cap_n = 0;

    always #5 clk = ~clk;

    descr100_rx #(.WIN_LEN(WIN), .RUN_MIN(25), .LOCK_CNT(30)) dut_i (
        .clk(clk), .rst(rst), .rx_bit(rx_bit), .rx_vld(rx_vld),
        .scr_bypass(scr_bypass), .mode_100(mode_100),
        .grp_data(grp_data), .grp_vld(grp_vld), .locked(locked)
    );

    always @(negedge clk) begin
        if (grp_vld && cap_n < 1024) begin
            cap[cap_n] = grp_data;
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One bit per call, driven at the falling edge; scrambled when scr_on.
    task automatic send_bit(input logic plain, input bit scr_on);
        logic k;
        k = scr[10] ^ scr[8];
        rx_bit = scr_on ? (plain ^ k) : plain;
        rx_vld = 1'b1;
        if (scr_on) scr = {scr[9:0], k};
        @(negedge clk);
    endtask

    task automatic gap();
        rx_vld = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_grp(input logic [4:0] g, input bit scr_on);
        for (int b = 4; b >= 0; b--) send_bit(g[b], scr_on);
    endtask

    task automatic send_ones(input int n, input bit scr_on);
        for (int i = 0; i < n; i++) send_bit(1'b1, scr_on);
    endtask

    task automatic frame_test(input bit scr_on, input string req);
        int base;
        base = cap_n;
        send_ones(7, scr_on);
        chk(cap_n == base, {req, " no group before delimiter"}, cap_n - base, 0);
        send_grp(5'b11000, scr_on);
        send_grp(5'b10001, scr_on);
        for (int i = 0; i < NV; i++) send_grp(VEC[i][9:5], scr_on);
        send_ones(3, scr_on);
        gap(); gap(); gap();
        chk(cap_n - base == NV + 2, {req, " group count"}, cap_n - base, NV + 2);
        chk(cap[base] == 5'b11000, {req, " R6 first delimiter group"}, int'(cap[base]), 24);
        chk(cap[base+1] == 5'b10001, {req, " R6 second delimiter group"}, int'(cap[base+1]), 17);
        for (int i = 0; i < NV; i++)
            chk(cap[base+2+i] == VEC[i][4:0], {req, " R2 group data"},
                int'(cap[base+2+i]), int'(VEC[i][4:0]));
    endtask

    initial begin
        int base;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(locked == 1'b0, "R1 locked in reset", int'(locked), 0);
        chk(grp_vld == 1'b0, "R1 grp_vld in reset", int'(grp_vld), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(locked == 1'b0 && grp_vld == 1'b0, "R1 after reset", int'(locked), 0);

        // R3: acquisition with idle cycles mixed in; 41 valid bits to lock
        for (int i = 0; i < 40; i++) begin
            send_bit(1'b1, 1'b1);
            if (i % 3 == 2) gap();
        end
        chk(locked == 1'b0, "R3 not locked after 40 bits", int'(locked), 0);
        send_bit(1'b1, 1'b1);
        chk(locked == 1'b1, "R3 locked after 41 bits", int'(locked), 1);
        chk(cap_n == 0, "R7 no groups during acquisition", cap_n, 0);

        // R2 R6: delimiter at an odd bit offset, then table of groups
        frame_test(1'b1, "R6 scrambled");

        // R4: runs of exactly 25 ones keep lock over three windows
        for (int r = 0; r < 35; r++) begin
            send_ones(25, 1'b1);
            send_bit(1'b0, 1'b1);
        end
        chk(locked == 1'b1, "R4 lock held with 25-runs", int'(locked), 1);

        // R5: runs of 24 ones lose lock
        for (int r = 0; r < 28; r++) begin
            send_ones(24, 1'b1);
            send_bit(1'b0, 1'b1);
        end
        chk(locked == 1'b0, "R5 lock lost with 24-runs", int'(locked), 0);
        base = cap_n;
        for (int r = 0; r < 2; r++) begin
            send_ones(24, 1'b1);
            send_bit(1'b0, 1'b1);
        end
        gap();
        chk(cap_n == base, "R7 no groups while unlocked", cap_n - base, 0);

        // R5: reacquire on idle
        send_ones(60, 1'b1);
        chk(locked == 1'b1, "R5 reacquired", int'(locked), 1);

        // R9: 10 Mb/s mode
        mode_100 = 1'b0;
        base = cap_n;
        @(negedge clk);
        chk(locked == 1'b0, "R9 locked low in 10M", int'(locked), 0);
        send_grp(5'b11000, 1'b1);
        send_grp(5'b10001, 1'b1);
        send_grp(5'b01010, 1'b1);
        scr_bypass = 1'b1;
        send_grp(5'b11000, 1'b0);
        send_grp(5'b10001, 1'b0);
        chk(locked == 1'b0, "R9 locked low in 10M with bypass", int'(locked), 0);
        gap(); gap();
        chk(cap_n == base, "R9 no groups in 10M", cap_n - base, 0);
        scr_bypass = 1'b0;
        mode_100 = 1'b1;
        @(negedge clk);
        chk(locked == 1'b0, "R9 reacquire needed", int'(locked), 0);

        // R3: one mismatch during verify restarts the load
        send_ones(31, 1'b1);
        send_bit(1'b0, 1'b1);
        send_ones(40, 1'b1);
        chk(locked == 1'b0, "R3 mismatch restarts, 40 bits", int'(locked), 0);
        send_bit(1'b1, 1'b1);
        chk(locked == 1'b1, "R3 mismatch restarts, 41 bits", int'(locked), 1);

        // R8: bypass passes raw bits and holds lock
        scr_bypass = 1'b1;
        gap();
        chk(locked == 1'b1, "R8 locked in bypass", int'(locked), 1);
        frame_test(1'b0, "R8 bypass");
        for (int i = 0; i < 400; i++) send_bit(1'b0, 1'b0);
        gap(); gap();
        chk(locked == 1'b1, "R8 no window drop in bypass", int'(locked), 1);
        chk(cap_n > 0 && cap[cap_n-1] == 5'b00000, "R8 raw zeros passed",
            int'(cap[cap_n-1]), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule